// File: doc/BRIEF.md
# Bus-Clocked Wiper Step Engine

This block runs the fine-tuning phase of a serial-bus digital potentiometer controller. Once the command engine has acknowledged the step instruction, it pulses `step_arm` and names a wiper channel. From then on, the serial clock no longer carries data bits. Every rising edge of the synchronized serial clock is one step command for the selected wiper. The level of the synchronized serial data line at that edge sets the direction: high moves the code one position toward the high terminal, and low moves it one position toward the low terminal.

A transfer may contain any number of steps in any mix of directions. The mode ends when the bus front end reports a stop or a start condition. The block holds only the volatile wiper codes. Preset storage, acknowledge generation and analog settling belong to other blocks. A code update appears on the outputs in the system clock cycle that first samples the serial clock high. This is far inside the wiper response budget of several microseconds.

Top module: `wiper_stepper`

## Requirements
- R1: After reset every wiper channel holds `RESET_CODE` and `stepping_o` is 0.
- R2: A one-cycle `step_arm` pulse sets `stepping_o` from the next cycle on and latches `step_chan` as the channel to be stepped. A later `step_arm` re-arms the mode with its new channel.
- R3: While stepping, a rising edge of `scl_i` with `sda_i` = 1 raises the selected code by one. The new code is visible from the clock edge that first samples `scl_i` high.
- R4: While stepping, a rising edge of `scl_i` with `sda_i` = 0 lowers the selected code by one, with the same timing as R3.
- R5: An up step on a code already at 2^CODE_W-1 leaves it unchanged. The code does not wrap.
- R6: A down step on a code already at 0 leaves it unchanged. The code does not wrap.
- R7: A `stop_det` pulse ends the mode, and `stepping_o` is 0 from the next cycle. Serial clock pulses after that leave every code unchanged.
- R8: A `start_det` pulse ends the mode in the same way as R7.
- R9: While not stepping, serial clock pulses of either data level leave every code unchanged.
- R10: A step changes only the latched channel. Every other channel holds its value.
- R11: One step is taken per rising edge. Holding `scl_i` high for many cycles, or changing `sda_i` while `scl_i` is high, adds no step. The direction is the `sda_i` level at the rising edge.
- R12: A rising edge that coincides with `stop_det`, `start_det` or `step_arm` is not a step. When `step_arm` and an exit indication arrive in the same cycle, the arm wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock, already synchronized to `clk` |
| sda_i | input | 1 | Serial data, already synchronized to `clk`; step direction (1 = up, 0 = down) |
| start_det | input | 1 | One-cycle pulse: start condition seen on the bus |
| stop_det | input | 1 | One-cycle pulse: stop condition seen on the bus |
| step_arm | input | 1 | One-cycle pulse from the command engine: step instruction acknowledged |
| step_chan | input | SEL_W | Wiper channel to be stepped, sampled with `step_arm` |
| wiper_o | output | N_CH*CODE_W | All wiper codes; channel i occupies bits i*CODE_W upward |
| stepping_o | output | 1 | High while step mode is active |

## Verification
The bench builds the engine with four channels, 4-bit codes and a reset code of 8. With these values, both saturation limits lie only a handful of serial clock pulses away, so hitting and pressing against the top and bottom codes costs only a few cycles. Four channels also leave room to step one channel while three neighbours, including ones above and below it in the output vector, must stay untouched. Exits by stop, exit by start, coincident edges and long clock-high intervals are each driven as separate directed scenarios against a reference array of expected codes.

// File: rtl/wiper_step_pkg.sv
package wiper_step_pkg;

    localparam int MAX_CODE_W = 16;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    typedef struct packed {
        logic      valid;
        step_dir_e dir;
    } step_cmd_t;

    // One saturating step; top is the highest legal code.
    function automatic logic [MAX_CODE_W-1:0] sat_step(
        input logic [MAX_CODE_W-1:0] code,
        input logic [MAX_CODE_W-1:0] top,
        input step_dir_e             dir
    );
        logic [MAX_CODE_W-1:0] res;
        res = code;
        if (dir == DIR_UP) begin
            if (code < top) res = code + 1'b1;
        end else begin
            if (code != '0) res = code - 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/scl_edge.sv
module scl_edge (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    output logic rise_o,
    output logic high_hold_o
);
    logic scl_q;

    // Idle bus level is high, so reset to 1 to avoid a false edge.
    always_ff @(posedge clk) begin
        if (rst) scl_q <= 1'b1;
        else     scl_q <= scl_i;
    end

    assign rise_o      = scl_i & ~scl_q;
    assign high_hold_o = scl_i & scl_q;
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
    import wiper_step_pkg::*;
#(
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_arm,
    input  logic [SEL_W-1:0] step_chan,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             rise,
    input  logic             sda_i,
    output logic             active_o,
    output logic [SEL_W-1:0] chan_o,
    output step_cmd_t        cmd_o
);
    logic exit_req;
    assign exit_req = start_det | stop_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            chan_o   <= '0;
        end else if (step_arm) begin
            active_o <= 1'b1;
            chan_o   <= step_chan;
        end else if (exit_req) begin
            active_o <= 1'b0;
        end
    end

    always_comb begin
        cmd_o.valid = active_o & rise & ~exit_req & ~step_arm;
        cmd_o.dir   = sda_i ? DIR_UP : DIR_DOWN;
    end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wiper_step_pkg::*;
#(
    parameter int N_CH       = 2,
    parameter int CODE_W     = 8,
    parameter int RESET_CODE = 128,
    parameter int SEL_W      = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  step_cmd_t                cmd,
    input  logic [SEL_W-1:0]         chan,
    output logic [N_CH*CODE_W-1:0]   codes_o
);
    localparam logic [MAX_CODE_W-1:0] CODE_TOP  = MAX_CODE_W'((1 << CODE_W) - 1);
    localparam logic [CODE_W-1:0]     CODE_INIT = CODE_W'(RESET_CODE);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [CODE_W-1:0]     code_q;
        logic [MAX_CODE_W-1:0] code_nxt;
        logic                  hit;

        assign hit      = cmd.valid && (chan == SEL_W'(i));
        assign code_nxt = sat_step(MAX_CODE_W'(code_q), CODE_TOP, cmd.dir);

        always_ff @(posedge clk) begin
            if (rst)      code_q <= CODE_INIT;
            else if (hit) code_q <= code_nxt[CODE_W-1:0];
        end

        assign codes_o[i*CODE_W +: CODE_W] = code_q;
    end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
    import wiper_step_pkg::*;
#(
    parameter  int N_CH       = 2,
    parameter  int CODE_W     = 8,
    parameter  int RESET_CODE = 128,
    localparam int SEL_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   start_det,
    input  logic                   stop_det,
    input  logic                   step_arm,
    input  logic [SEL_W-1:0]       step_chan,
    output logic [N_CH*CODE_W-1:0] wiper_o,
    output logic                   stepping_o
);
    logic             rise;
    logic             high_hold;
    logic [SEL_W-1:0] chan;
    step_cmd_t        cmd;

    scl_edge u_edge (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_i),
        .rise_o      (rise),
        .high_hold_o (high_hold)
    );

    step_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .step_arm  (step_arm),
        .step_chan (step_chan),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rise      (rise),
        .sda_i     (sda_i),
        .active_o  (stepping_o),
        .chan_o    (chan),
        .cmd_o     (cmd)
    );

    wiper_bank #(
        .N_CH       (N_CH),
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE),
        .SEL_W      (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .chan    (chan),
        .codes_o (wiper_o)
    );

    // Held-high samples must never produce a step (R11).
    always_comb begin
        if (!rst) assert (!(high_hold && cmd.valid));
    end
endmodule

// File: rtl/wiper_step_chk.sv
module wiper_step_chk #(
    parameter  int N_CH   = 2,
    parameter  int CODE_W = 8,
    localparam int SEL_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_i,
    input logic                   sda_i,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   step_arm,
    input logic [SEL_W-1:0]       step_chan,
    input logic [N_CH*CODE_W-1:0] wiper_o,
    input logic                   stepping_o
);
    localparam logic [CODE_W-1:0] TOP = '1;

    logic             prev_scl;
    logic [SEL_W-1:0] sel_q;
    logic [CODE_W-1:0] cur;
    logic             edge_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_scl <= 1'b1;
            sel_q    <= '0;
        end else begin
            prev_scl <= scl_i;
            if (step_arm) sel_q <= step_chan;
        end
    end

    assign cur     = wiper_o[sel_q*CODE_W +: CODE_W];
    assign edge_ok = stepping_o && scl_i && !prev_scl && !start_det && !stop_det && !step_arm;

    a_r2_arm_enters: assert property (@(posedge clk) disable iff (rst)
        step_arm |=> stepping_o);

    a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
        edge_ok && sda_i && cur != TOP |=> cur == $past(cur) + 1'b1);

    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        edge_ok && !sda_i && cur != '0 |=> cur == $past(cur) - 1'b1);

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        edge_ok && sda_i && cur == TOP |=> cur == TOP);

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        edge_ok && !sda_i && cur == '0 |=> cur == '0);

    a_r7_stop_exits: assert property (@(posedge clk) disable iff (rst)
        stop_det && !step_arm |=> !stepping_o);

    a_r8_start_exits: assert property (@(posedge clk) disable iff (rst)
        start_det && !step_arm |=> !stepping_o);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !stepping_o |=> $stable(wiper_o));

    a_r11_held_high: assert property (@(posedge clk) disable iff (rst)
        scl_i && prev_scl |=> $stable(wiper_o));

    a_r12_coincide: assert property (@(posedge clk) disable iff (rst)
        (start_det || stop_det || step_arm) |=> $stable(wiper_o));

    for (genvar i = 0; i < N_CH; i++) begin : g_other
        a_r10_others_hold: assert property (@(posedge clk) disable iff (rst)
            sel_q != SEL_W'(i) |=> $stable(wiper_o[i*CODE_W +: CODE_W]));
    end
endmodule

bind wiper_stepper wiper_step_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .step_arm   (step_arm),
    .step_chan  (step_chan),
    .wiper_o    (wiper_o),
    .stepping_o (stepping_o)
);

// File: tb/wiper_stepper_test.sv
`timescale 1ns/1ps
module wiper_stepper_test;
    localparam int N_CH   = 4;
    localparam int CODE_W = 4;
    localparam int RST_V  = 8;
    localparam int TOPV   = (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst, scl, sda, start_det, stop_det, step_arm;
    logic [1:0] step_chan;
    logic [N_CH*CODE_W-1:0] wiper;
    logic stepping;

    int n_chk = 0;
    int n_bad = 0;
    int expv [N_CH];

    always #5 clk = ~clk;

    wiper_stepper #(.N_CH(N_CH), .CODE_W(CODE_W), .RESET_CODE(RST_V)) uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .start_det(start_det), .stop_det(stop_det),
        .step_arm(step_arm), .step_chan(step_chan),
        .wiper_o(wiper), .stepping_o(stepping)
    );

    task automatic check_codes(input string req);
        for (int i = 0; i < N_CH; i++) begin
            n_chk++;
            if (int'(wiper[i*CODE_W +: CODE_W]) != expv[i]) begin
                n_bad++;
                $display("FAIL %s ch%0d: actual %0d expected %0d", req, i,
                         wiper[i*CODE_W +: CODE_W], expv[i]);
            end
        end
    endtask

    task automatic check_mode(input string req, input logic exp_m);
        n_chk++;
        if (stepping !== exp_m) begin
            n_bad++;
            $display("FAIL %s stepping: actual %b expected %b", req, stepping, exp_m);
        end
    endtask

    task automatic pulse(input logic d);
        @(negedge clk) sda = d; scl = 1'b0;
        @(negedge clk) scl = 1'b1;
        @(negedge clk);
        @(negedge clk) scl = 1'b0;
        @(negedge clk);
    endtask

    task automatic arm(input int ch);
        @(negedge clk) step_arm = 1'b1; step_chan = 2'(ch);
        @(negedge clk) step_arm = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
    endtask

    task automatic model(input int ch, input logic d);
        if (d) begin if (expv[ch] < TOPV) expv[ch]++; end
        else   begin if (expv[ch] > 0)    expv[ch]--; end
    endtask

    task automatic t_reset();
        for (int i = 0; i < N_CH; i++) expv[i] = RST_V;
        check_codes("R1");
        check_mode("R1", 1'b0);
    endtask

    task automatic t_idle();
        pulse(1'b1); pulse(1'b0); pulse(1'b1);
        check_codes("R9");
        check_mode("R9", 1'b0);
    endtask

    task automatic t_up_down();
        arm(1);
        check_mode("R2", 1'b1);
        for (int k = 0; k < 3; k++) begin pulse(1'b1); model(1, 1'b1); end
        check_codes("R3 R10");
        for (int k = 0; k < 5; k++) begin pulse(1'b0); model(1, 1'b0); end
        check_codes("R4 R10");
        pulse(1'b1); model(1, 1'b1);
        pulse(1'b0); model(1, 1'b0);
        pulse(1'b0); model(1, 1'b0);
        check_codes("R3 R4 mixed");
        bus_stop();
    endtask

    task automatic t_sat_hi();
        arm(2);
        for (int k = 0; k < 10; k++) begin pulse(1'b1); model(2, 1'b1); end
        check_codes("R5");
        bus_stop();
    endtask

    task automatic t_sat_lo();
        arm(3);
        for (int k = 0; k < 11; k++) begin pulse(1'b0); model(3, 1'b0); end
        check_codes("R6");
        bus_stop();
    endtask

    task automatic t_stop();
        arm(0);
        pulse(1'b1); model(0, 1'b1);
        bus_stop();
        check_mode("R7", 1'b0);
        pulse(1'b1); pulse(1'b0);
        check_codes("R7");
    endtask

    task automatic t_start();
        arm(1);
        pulse(1'b0); model(1, 1'b0);
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
        check_mode("R8", 1'b0);
        pulse(1'b0); pulse(1'b1);
        check_codes("R8");
    endtask

    task automatic t_hold();
        arm(0);
        @(negedge clk) sda = 1'b0; scl = 1'b0;
        @(negedge clk) scl = 1'b1;
        for (int k = 0; k < 10; k++) @(negedge clk) sda = ~sda;
        @(negedge clk) scl = 1'b0;
        @(negedge clk);
        model(0, 1'b0);
        check_codes("R11");
        bus_stop();
    endtask

    task automatic t_coincide();
        arm(2);
        @(negedge clk) sda = 1'b0; scl = 1'b0;
        @(negedge clk) scl = 1'b1; stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
        @(negedge clk) scl = 1'b0;
        @(negedge clk);
        check_codes("R12 stop edge");
        check_mode("R12", 1'b0);
        @(negedge clk) step_arm = 1'b1; step_chan = 2'd3; start_det = 1'b1;
        @(negedge clk) step_arm = 1'b0; start_det = 1'b0;
        check_mode("R12 arm wins", 1'b1);
        pulse(1'b1); model(3, 1'b1);
        check_codes("R2 R12 rearm");
        bus_stop();
    endtask

    initial begin
        rst = 1'b1; scl = 1'b1; sda = 1'b1;
        start_det = 1'b0; stop_det = 1'b0; step_arm = 1'b0; step_chan = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_up_down();
        t_sat_hi();
        t_sat_lo();
        t_stop();
        t_start();
        t_hold();
        t_coincide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule